// File: doc/BRIEF.md
# Reset-Time Debug Mode Selector

This block decides, once per reset sequence, which debug facility the chip brings up. It watches the power-on/test reset, the system reset and a compliance input, and reads a few strap pins at fixed points around their release. The possible results are a background debug mode, with a clock-mode choice, or a trace auxiliary port in one of two widths. If neither set of strap conditions holds, no debug mode is active.

Background debug is chosen by the debug clock pin at the moment the system reset is released. Its clock mode follows the debug data-in pin during a short window after that release. The auxiliary port is armed only if the compliance input is low when the power-on reset is released. It is enabled when the compliance input later rises, provided the event pin has been low and the width pin steady for a minimum number of clocks just before the rise. The width pin selects either the wide lane pair (2 in, 8 out) or the narrow pair (1 in, 2 out). All results are held in registers until the next reset sequence. All inputs are assumed already synchronous to `clk`.

Top module: `dbg_mode_select`

## Requirements
- R1: While `por_rst` is high at a clock edge, all outputs are cleared by that edge (synchronous, active high): `bdm_en`, `bdm_clk_mode`, `aux_en` and `aux_full` are 0, and both lane counts are 0.
- R2: At the clock edge where `sys_rst` is seen low after being high, `bdm_en` takes the value of `dbg_clk_pin`.
- R3: `bdm_clk_mode` takes `dbg_din_pin` at the release edge and at each of the next 7 edges (8 samples in all, the last one kept) when `bdm_en` is 1. After that window it stays frozen. It is 0 whenever `bdm_en` is 0.
- R4: If `rst_en` is high at the edge where `por_rst` is released, the auxiliary port stays disabled for the rest of that sequence.
- R5: At the first rising edge of `rst_en` after an armed power-on release, `aux_en` becomes 1 only if `evt_pin` was low and `width_pin` unchanged at each of the 4 clock edges just before the rise. A shorter hold leaves it 0.
- R6: A change of `width_pin` that is applied within the last 4 clock cycles before the `rst_en` rise keeps `aux_en` at 0.
- R7: When the port is enabled, `aux_full` equals `width_pin` at the rise edge. The lane counts are then 2 in and 8 out for full width, 1 in and 2 out for reduced width. When the port is disabled, `aux_full` and both lane counts are 0.
- R8: `bdm_en` and `aux_en` are never both 1. A release that enables background debug clears the auxiliary port in the same edge. A `rst_en` rise while `bdm_en` is 1 leaves the port off.
- R9: Once decided, the auxiliary outputs ignore later `rst_en` toggles and later changes of `evt_pin` and `width_pin`. `bdm_en` ignores changes of `dbg_clk_pin` after its release edge.
- R10: Both the window counter and the setup counter saturate. Holding `evt_pin` low for many more than 4 cycles still enables the port, and toggling `dbg_din_pin` long after the window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on/test reset, active high |
| sys_rst | input | 1 | System reset, active high; its release starts background-debug sampling |
| rst_en | input | 1 | Compliance/reset-enable; low at power-on release arms the port, its rise commits it |
| dbg_clk_pin | input | 1 | Debug clock strap, selects background debug |
| dbg_din_pin | input | 1 | Debug data-in strap, selects background-debug clock mode |
| evt_pin | input | 1 | Event strap, must be low to enable the auxiliary port |
| width_pin | input | 1 | Port width strap: 1 full, 0 reduced |
| bdm_en | output | 1 | Background debug mode enabled |
| bdm_clk_mode | output | 1 | Background debug clock-mode select |
| aux_en | output | 1 | Auxiliary trace port enabled |
| aux_full | output | 1 | Auxiliary port is full width |
| aux_in_lanes | output | LANE_W | Active input lane count |
| aux_out_lanes | output | LANE_W | Active output lane count |

## Verification
Every result is registered and appears right after the edge that samples its trigger. `bdm_en` and the first `bdm_clk_mode` value are valid after the system-reset release edge. Each later clock-mode sample is valid after its own edge. The auxiliary flags and lane counts are valid after the edge that sees `rst_en` rise. The bench drives pins 1 ns after a rising edge and reads outputs 1 ns after the next one, so each check looks at exactly the edge its trigger was applied to. Hold lengths and toggle positions are swept by counting those edges.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;

    localparam int unsigned DEF_WIN      = 8;
    localparam int unsigned DEF_SETUP    = 4;
    localparam int unsigned DEF_LANE_W   = 4;
    localparam int unsigned DEF_FULL_IN  = 2;
    localparam int unsigned DEF_FULL_OUT = 8;
    localparam int unsigned DEF_RED_IN   = 1;
    localparam int unsigned DEF_RED_OUT  = 2;

    typedef struct packed {
        logic en;
        logic full;
    } aux_sel_t;

    function automatic int unsigned pick_lanes(input logic en, input logic full,
                                               input int unsigned full_n,
                                               input int unsigned red_n);
        if (!en) return 0;
        return full ? full_n : red_n;
    endfunction

endpackage

// File: rtl/dbgsel_edge.sv
module dbgsel_edge #(
    parameter bit RISING  = 1'b1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic evt
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = sig & ~q;
        end else begin : g_fall
            assign evt = q & ~sig;
        end
    endgenerate
endmodule

// File: rtl/dbgsel_bdm_sampler.sv
module dbgsel_bdm_sampler #(
    parameter int unsigned WIN = dbgsel_pkg::DEF_WIN
) (
    input  logic clk,
    input  logic por_rst,
    input  logic sys_fall,
    input  logic dbg_clk_pin,
    input  logic dbg_din_pin,
    output logic bdm_en,
    output logic clk_mode,
    output logic take
);
    localparam int unsigned WW = $clog2(WIN + 1);
    localparam logic [WW-1:0] WMAX = WW'(WIN);

    logic [WW-1:0] win;

    assign take = sys_fall & dbg_clk_pin;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            bdm_en   <= 1'b0;
            clk_mode <= 1'b0;
            win      <= WMAX;
        end else if (sys_fall) begin
            bdm_en   <= dbg_clk_pin;
            clk_mode <= dbg_clk_pin & dbg_din_pin;
            win      <= WW'(1);
        end else if (win != WMAX) begin
            win <= win + WW'(1);
            if (bdm_en) clk_mode <= dbg_din_pin;
        end
    end

    assert_win_sat_R10: assert property (@(posedge clk) disable iff (por_rst)
        win <= WMAX);
    assert_bdm_latch_R2: assert property (@(posedge clk) disable iff (por_rst)
        sys_fall |=> (bdm_en == $past(dbg_clk_pin)));
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (por_rst)
        (win == WMAX && !sys_fall) |=> $stable(clk_mode));
    assert_mode_off_R3: assert property (@(posedge clk) disable iff (por_rst)
        !bdm_en |-> !clk_mode);
endmodule

// File: rtl/dbgsel_aux_sampler.sv
module dbgsel_aux_sampler #(
    parameter int unsigned SETUP = dbgsel_pkg::DEF_SETUP
) (
    input  logic clk,
    input  logic por_rst,
    input  logic por_fall,
    input  logic en_rise,
    input  logic rst_en,
    input  logic evt_pin,
    input  logic width_pin,
    output logic go,
    output logic go_full
);
    localparam int unsigned CW = $clog2(SETUP + 1);
    localparam logic [CW-1:0] CMAX = CW'(SETUP);

    logic          armed;
    logic          width_q;
    logic [CW-1:0] cnt;
    logic          steady;

    assign steady  = !evt_pin && (width_pin == width_q);
    assign go      = armed && en_rise && (cnt == CMAX);
    assign go_full = width_pin;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            armed   <= 1'b0;
            width_q <= 1'b0;
            cnt     <= '0;
        end else begin
            width_q <= width_pin;
            if (por_fall)     armed <= ~rst_en;
            else if (en_rise) armed <= 1'b0;
            if (!steady)           cnt <= '0;
            else if (cnt != CMAX)  cnt <= cnt + CW'(1);
        end
    end

    assert_setup_sat_R10: assert property (@(posedge clk) disable iff (por_rst)
        cnt <= CMAX);
    assert_go_evt_low_R5: assert property (@(posedge clk) disable iff (por_rst)
        go |-> !$past(evt_pin));
endmodule

// File: rtl/dbg_mode_select.sv
module dbg_mode_select #(
    parameter int unsigned WIN      = dbgsel_pkg::DEF_WIN,
    parameter int unsigned SETUP    = dbgsel_pkg::DEF_SETUP,
    parameter int unsigned LANE_W   = dbgsel_pkg::DEF_LANE_W,
    parameter int unsigned FULL_IN  = dbgsel_pkg::DEF_FULL_IN,
    parameter int unsigned FULL_OUT = dbgsel_pkg::DEF_FULL_OUT,
    parameter int unsigned RED_IN   = dbgsel_pkg::DEF_RED_IN,
    parameter int unsigned RED_OUT  = dbgsel_pkg::DEF_RED_OUT
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              rst_en,
    input  logic              dbg_clk_pin,
    input  logic              dbg_din_pin,
    input  logic              evt_pin,
    input  logic              width_pin,
    output logic              bdm_en,
    output logic              bdm_clk_mode,
    output logic              aux_en,
    output logic              aux_full,
    output logic [LANE_W-1:0] aux_in_lanes,
    output logic [LANE_W-1:0] aux_out_lanes
);
    import dbgsel_pkg::*;

    logic     por_fall, sys_fall, en_rise;
    logic     take, go, go_full;
    aux_sel_t aux_q;

    dbgsel_edge #(.RISING(1'b0), .RST_VAL(1'b1)) u_por_edge (
        .clk(clk), .rst(1'b0), .sig(por_rst), .evt(por_fall));
    dbgsel_edge #(.RISING(1'b0), .RST_VAL(1'b0)) u_sys_edge (
        .clk(clk), .rst(por_rst), .sig(sys_rst), .evt(sys_fall));
    dbgsel_edge #(.RISING(1'b1), .RST_VAL(1'b1)) u_en_edge (
        .clk(clk), .rst(por_rst), .sig(rst_en), .evt(en_rise));

    dbgsel_bdm_sampler #(.WIN(WIN)) u_bdm (
        .clk(clk), .por_rst(por_rst), .sys_fall(sys_fall),
        .dbg_clk_pin(dbg_clk_pin), .dbg_din_pin(dbg_din_pin),
        .bdm_en(bdm_en), .clk_mode(bdm_clk_mode), .take(take));

    dbgsel_aux_sampler #(.SETUP(SETUP)) u_aux (
        .clk(clk), .por_rst(por_rst), .por_fall(por_fall), .en_rise(en_rise),
        .rst_en(rst_en), .evt_pin(evt_pin), .width_pin(width_pin),
        .go(go), .go_full(go_full));

    always_ff @(posedge clk) begin
        if (por_rst || take) begin
            aux_q         <= '0;
            aux_in_lanes  <= '0;
            aux_out_lanes <= '0;
        end else if (go && !bdm_en) begin
            aux_q.en      <= 1'b1;
            aux_q.full    <= go_full;
            aux_in_lanes  <= LANE_W'(pick_lanes(1'b1, go_full, FULL_IN, RED_IN));
            aux_out_lanes <= LANE_W'(pick_lanes(1'b1, go_full, FULL_OUT, RED_OUT));
        end
    end

    assign aux_en   = aux_q.en;
    assign aux_full = aux_q.full;

    assert_excl_R8: assert property (@(posedge clk) disable iff (por_rst)
        !(bdm_en && aux_en));
    assert_take_clears_R8: assert property (@(posedge clk) disable iff (por_rst)
        take |=> !aux_en);
    assert_lanes_off_R7: assert property (@(posedge clk) disable iff (por_rst)
        !aux_en |-> (aux_in_lanes == '0 && aux_out_lanes == '0 && !aux_full));
    assert_full_lanes_R7: assert property (@(posedge clk) disable iff (por_rst)
        (aux_en && aux_full) |-> (aux_out_lanes == LANE_W'(FULL_OUT)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (por_rst)
        (!go && !take) |=> $stable(aux_en));
endmodule

// File: tb/dbg_mode_select_bench.sv
module dbg_mode_select_bench;
    logic clk = 1'b0;
    logic por_rst, sys_rst, rst_en, dbg_clk_pin, dbg_din_pin, evt_pin, width_pin;
    logic bdm_en, bdm_clk_mode, aux_en, aux_full;
    logic [3:0] aux_in_lanes, aux_out_lanes;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_mode_select u_dbg_mode_select (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .rst_en(rst_en),
        .dbg_clk_pin(dbg_clk_pin), .dbg_din_pin(dbg_din_pin),
        .evt_pin(evt_pin), .width_pin(width_pin),
        .bdm_en(bdm_en), .bdm_clk_mode(bdm_clk_mode),
        .aux_en(aux_en), .aux_full(aux_full),
        .aux_in_lanes(aux_in_lanes), .aux_out_lanes(aux_out_lanes));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_aux(input string tag, input logic en, input logic full);
        int ein, eout;
        ein  = !en ? 0 : (full ? 2 : 1);
        eout = !en ? 0 : (full ? 8 : 2);
        check({tag, " aux_en"}, 32'(aux_en), 32'(en));
        check({tag, " aux_full"}, 32'(aux_full), 32'(en & full));
        check({tag, " in_lanes"}, 32'(aux_in_lanes), 32'(ein));
        check({tag, " out_lanes"}, 32'(aux_out_lanes), 32'(eout));
    endtask

    task automatic start_seq(input logic en_at_release);
        por_rst = 1'b1; sys_rst = 1'b1; rst_en = 1'b0;
        evt_pin = 1'b1; width_pin = 1'b0; dbg_clk_pin = 1'b0; dbg_din_pin = 1'b0;
        repeat (3) tick();
        rst_en = en_at_release;
        por_rst = 1'b0;
        tick();
        tick();
    endtask

    task automatic all_zero(input string tag);
        check({tag, " bdm_en"}, 32'(bdm_en), 0);
        check({tag, " bdm_clk_mode"}, 32'(bdm_clk_mode), 0);
        check_aux(tag, 1'b0, 1'b0);
    endtask

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hA5C3; pats[1] = 16'h0080; pats[2] = 16'h7F7F; pats[3] = 16'hFF00;

        // R1: reset state
        start_seq(1'b0);
        all_zero("R1 after power-on");

        // R2, R3, R10: background debug sampling window
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 2; d++) begin
                start_seq(1'b0);
                dbg_clk_pin = d[0];
                dbg_din_pin = pats[p][0];
                sys_rst = 1'b0;
                tick();
                check("R2 bdm_en at release", 32'(bdm_en), 32'(d));
                for (int k = 0; k < 20; k++) begin
                    if (k > 0) begin
                        dbg_din_pin = pats[p][k % 16];
                        tick();
                    end
                    check((k < 8) ? "R3 clk_mode in window" : "R10 clk_mode after window",
                          32'(bdm_clk_mode),
                          32'(d[0] & pats[p][(k < 8) ? k : 7]));
                end
                dbg_clk_pin = ~d[0];
                tick();
                check("R9 bdm_en holds", 32'(bdm_en), 32'(d));
                check("R8 aux off in bdm sweep", 32'(aux_en), 0);
            end
        end

        // R5, R7, R9: setup-hold length sweep for both widths
        for (int n = 0; n < 8; n++) begin
            for (int w = 0; w < 2; w++) begin
                logic exp_en;
                exp_en = (n >= 4);
                start_seq(1'b0);
                width_pin = w[0];
                tick(); tick();
                evt_pin = 1'b0;
                repeat (n) tick();
                rst_en = 1'b1;
                tick();
                check_aux(exp_en ? "R5 R7 enabled" : "R5 short hold", exp_en, w[0]);
                rst_en = 1'b0; tick();
                evt_pin = 1'b1; width_pin = ~w[0]; tick();
                rst_en = 1'b1; tick();
                check_aux("R9 later toggles ignored", exp_en, w[0]);
            end
        end

        // R6: width change position sweep
        for (int k = 1; k <= 5; k++) begin
            start_seq(1'b0);
            width_pin = 1'b0; evt_pin = 1'b0;
            repeat (6) tick();
            repeat (5 - k) tick();
            width_pin = 1'b1;
            repeat (k) tick();
            rst_en = 1'b1;
            tick();
            check_aux((k < 5) ? "R6 late width change" : "R6 change before window", k == 5, 1'b1);
        end

        // R4: compliance input high at power-on release
        start_seq(1'b1);
        evt_pin = 1'b0; width_pin = 1'b1;
        repeat (6) tick();
        rst_en = 1'b0; tick();
        rst_en = 1'b1; tick();
        check_aux("R4 not armed", 1'b0, 1'b0);

        // R8: background debug release clears an enabled port
        start_seq(1'b0);
        width_pin = 1'b1; evt_pin = 1'b0;
        repeat (5) tick();
        rst_en = 1'b1; tick();
        check_aux("R8 port on before release", 1'b1, 1'b1);
        dbg_clk_pin = 1'b1; sys_rst = 1'b0; tick();
        check("R8 bdm wins", 32'(bdm_en), 1);
        check_aux("R8 port cleared", 1'b0, 1'b0);

        // R1: power-on reset clears everything again
        por_rst = 1'b1; tick();
        all_zero("R1 reassert");

        // R8: rise while background debug active
        start_seq(1'b0);
        dbg_clk_pin = 1'b1; sys_rst = 1'b0; tick();
        evt_pin = 1'b0; width_pin = 1'b0;
        repeat (6) tick();
        rst_en = 1'b1; tick();
        check("R8 bdm stays", 32'(bdm_en), 1);
        check_aux("R8 port blocked", 1'b0, 1'b0);

        // R8: no background debug, port allowed
        start_seq(1'b0);
        dbg_clk_pin = 1'b0; sys_rst = 1'b0; tick();
        evt_pin = 1'b0; width_pin = 1'b0;
        repeat (6) tick();
        rst_en = 1'b1; tick();
        check("R8 bdm off", 32'(bdm_en), 0);
        check_aux("R8 reduced port on", 1'b1, 1'b0);

        // R10: long hold does not wrap the setup counter
        start_seq(1'b0);
        width_pin = 1'b1; evt_pin = 1'b0;
        repeat (40) tick();
        rst_en = 1'b1; tick();
        check_aux("R10 long hold", 1'b1, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule